// File: doc/BRIEF.md
# Bus Parity and System Error Scanner

This block sweeps a fixed table of bus functions and looks for parity and system errors in their configuration status words. It reads the status words through a simple request/acknowledge config-read port and adds the errors it finds to a running count. When a software-controlled enable is high, a new sweep starts once per programmable poll period. Each sweep visits every function in ascending index order.

Each function has two flags, both supplied as inputs. One marks it as a bridge, meaning configuration header type 1. For a bridge, the secondary status word is read after the primary one, which catches errors on the bus behind the bridge. The other flag marks a device whose parity reporting is known to be unreliable. Such a device is passed over entirely.

The primary status word is judged on its own bits only. No parity-response enable setting gates the check. A separate panic enable turns any counted error into a sticky panic request.

Top module: `pci_parity_scanner`

## Requirements
- R1: For every function whose skip flag is low, one primary status read is issued per sweep (`cfg_sec`=0). Bit 15 (detected parity error) and bit 14 (signalled system error) of the returned word are both counted. All other bits are ignored.
- R2: A function whose bridge flag is high also gets one secondary status read (`cfg_sec`=1), issued after its primary read. Bits 15 and 14 of that word are counted in the same way. Functions that are not bridges are never read with `cfg_sec`=1.
- R3: A function whose skip flag is high is never read, and it adds nothing to the count.
- R4: While `scan_en` is low, no sweep starts. The first sweep's first request appears exactly POLL_CYCLES cycles after `scan_en` is first sampled high. Lowering `scan_en` lets the running sweep finish and starts no further sweep.
- R5: While `scan_en` stays high and a sweep is shorter than the poll period, successive sweeps start exactly POLL_CYCLES cycles apart.
- R6: On the cycle a read is acknowledged, `err_count` grows by the number of set bits among bits 15 and 14 of `cfg_status`. It saturates at its all-ones value and never changes on any other cycle.
- R7: `panic_req` rises one cycle after an acknowledged read that carries a counted error while `panic_en` is high. It then stays high until reset. With `panic_en` low, errors never raise it.
- R8: A request holds `cfg_fn` and `cfg_sec` stable until `cfg_ack` is seen. The status word is sampled only in the cycle of the acknowledge.
- R9: After reset, `err_count` is 0, `panic_req` is 0 and `cfg_req` is 0.
- R10: Within a sweep, reads follow ascending function index, and each bridge's primary read comes before its secondary read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Periodic sweep enable |
| panic_en | input | 1 | Turns counted errors into a panic request |
| fn_is_bridge | input | NUM_FN | Per function: header type 1 (bridge) |
| fn_skip | input | NUM_FN | Per function: unreliable parity, do not scan |
| cfg_req | output | 1 | Config read request |
| cfg_fn | output | IDX_W | Function index of the request |
| cfg_sec | output | 1 | 0 selects the primary status, 1 the secondary status |
| cfg_ack | input | 1 | Read data valid this cycle |
| cfg_status | input | 16 | Returned status word |
| err_count | output | CNT_W | Saturating error count |
| panic_req | output | 1 | Sticky panic request |

## Verification
Two functions can coincide in one cycle. One is a status update of the count that also raises the panic request. The other is the poll tick that arrives while a sweep is still in flight or just as `scan_en` is dropped. The bench provokes the first with random status words whose two error bits are both set under a random panic enable, and with sweeps that drive the count into saturation. It judges the result by comparing count and panic against a bench model after every sweep. The bench provokes the second by dropping the enable right after a sweep starts, or right after a second sweep starts. It then requires exactly one or two sweeps of reads, with no read in a long quiet window afterwards.

// File: rtl/pci_parity_scanner.sv
module pci_parity_scanner #(
  parameter int NUM_FN      = 8,
  parameter int POLL_CYCLES = 1000,
  parameter int CNT_W       = 16,
  localparam int IDX_W      = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic              panic_en,
  input  logic [NUM_FN-1:0] fn_is_bridge,
  input  logic [NUM_FN-1:0] fn_skip,
  output logic              cfg_req,
  output logic [IDX_W-1:0]  cfg_fn,
  output logic              cfg_sec,
  input  logic              cfg_ack,
  input  logic [15:0]       cfg_status,
  output logic [CNT_W-1:0]  err_count,
  output logic              panic_req
);
  localparam int TMR_W = (POLL_CYCLES > 2) ? $clog2(POLL_CYCLES) : 1;

  typedef enum logic [1:0] {S_IDLE, S_PRI, S_SEC, S_NEXT} st_t;

  st_t              st;
  logic [IDX_W-1:0] idx;
  logic [TMR_W-1:0] tmr;
  logic             tick;
  logic             take;
  logic [1:0]       hits;
  logic [CNT_W:0]   sum;

  assign tick    = scan_en && (tmr == TMR_W'(POLL_CYCLES - 1));
  assign cfg_req = ((st == S_PRI) && !fn_skip[idx]) || (st == S_SEC);
  assign cfg_fn  = idx;
  assign cfg_sec = (st == S_SEC);
  assign take    = cfg_req && cfg_ack;
  assign hits    = {1'b0, cfg_status[15]} + {1'b0, cfg_status[14]};
  assign sum     = {1'b0, err_count} + (CNT_W+1)'(hits);

  always_ff @(posedge clk) begin
    if (!rst_n || !scan_en || tick) tmr <= '0;
    else                            tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      idx <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (tick) begin
          idx <= '0;
          st  <= S_PRI;
        end
        S_PRI: begin
          if (fn_skip[idx])  st <= S_NEXT;
          else if (cfg_ack)  st <= fn_is_bridge[idx] ? S_SEC : S_NEXT;
        end
        S_SEC: if (cfg_ack) st <= S_NEXT;
        S_NEXT: begin
          if (idx == IDX_W'(NUM_FN - 1)) st <= S_IDLE;
          else begin
            idx <= idx + 1'b1;
            st  <= S_PRI;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_count <= '0;
      panic_req <= 1'b0;
    end else if (take) begin
      err_count <= sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
      if (panic_en && (hits != 2'd0)) panic_req <= 1'b1;
    end
  end
endmodule

module pci_parity_scanner_chk #(
  parameter int NUM_FN = 8,
  parameter int CNT_W  = 16,
  localparam int IDX_W = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              panic_en,
  input logic [NUM_FN-1:0] fn_is_bridge,
  input logic [NUM_FN-1:0] fn_skip,
  input logic              cfg_req,
  input logic [IDX_W-1:0]  cfg_fn,
  input logic              cfg_sec,
  input logic              cfg_ack,
  input logic [CNT_W-1:0]  err_count,
  input logic              panic_req
);
  // R3
  skip_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> !fn_skip[cfg_fn]);
  // R2
  sec_only_bridge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_sec) |-> fn_is_bridge[cfg_fn]);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_ack) |=> (cfg_req && $stable(cfg_fn) && $stable(cfg_sec)));
  // R6
  count_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_req && cfg_ack) |=> (err_count == $past(err_count)));
  // R6
  count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_ack) |=> (err_count >= $past(err_count)));
  // R7
  panic_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    panic_req |=> panic_req);
  // R7
  panic_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!panic_req && !panic_en) |=> !panic_req);
endmodule

bind pci_parity_scanner pci_parity_scanner_chk #(.NUM_FN(NUM_FN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .panic_en(panic_en), .fn_is_bridge(fn_is_bridge),
  .fn_skip(fn_skip), .cfg_req(cfg_req), .cfg_fn(cfg_fn), .cfg_sec(cfg_sec),
  .cfg_ack(cfg_ack), .err_count(err_count), .panic_req(panic_req)
);

// File: tb/pci_parity_scanner_bench.sv
module pci_parity_scanner_bench;
  localparam int NUM_FN = 8;
  localparam int POLL   = 200;
  localparam int CNT_W  = 6;
  localparam int IDX_W  = 3;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0, scan_en = 0, panic_en = 0;
  logic [NUM_FN-1:0] fn_is_bridge = '0, fn_skip = '0;
  logic cfg_req, cfg_sec, cfg_ack, panic_req;
  logic [IDX_W-1:0] cfg_fn;
  logic [15:0] cfg_status;
  logic [CNT_W-1:0] err_count;

  always #2.5 clk = ~clk;

  pci_parity_scanner #(.NUM_FN(NUM_FN), .POLL_CYCLES(POLL), .CNT_W(CNT_W)) u_pci_parity_scanner (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .panic_en(panic_en),
    .fn_is_bridge(fn_is_bridge), .fn_skip(fn_skip), .cfg_req(cfg_req),
    .cfg_fn(cfg_fn), .cfg_sec(cfg_sec), .cfg_ack(cfg_ack),
    .cfg_status(cfg_status), .err_count(err_count), .panic_req(panic_req));

  logic [15:0] pri_tab [NUM_FN];
  logic [15:0] sec_tab [NUM_FN];
  int pri_rd [NUM_FN];
  int sec_rd [NUM_FN];
  int last_key, order_err, stab_err, starts, cyc;
  int start_cyc [4];
  int checks = 0, failures = 0;
  int model_cnt = 0;
  bit model_panic = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin : responder
    bit pend = 0;
    logic [IDX_W-1:0] p_fn;
    bit p_sec;
    int wcnt;
    cfg_ack = 0;
    cfg_status = '0;
    forever begin
      @(negedge clk);
      cfg_ack = 0;
      if (rst_n && cfg_req) begin
        if (!pend) begin
          int key;
          pend = 1;
          p_fn = cfg_fn;
          p_sec = cfg_sec;
          wcnt = $urandom_range(0, 3);
          key = int'(cfg_fn) * 2 + int'(cfg_sec);
          if (key <= last_key && key != 0) order_err++;
          last_key = key;
          if (cfg_fn == 0 && !cfg_sec) begin
            if (starts < 4) start_cyc[starts] = cyc;
            starts++;
          end
        end else if (cfg_fn != p_fn || cfg_sec != p_sec) stab_err++;
        if (wcnt == 0) begin
          cfg_ack = 1;
          cfg_status = p_sec ? sec_tab[p_fn] : pri_tab[p_fn];
          if (p_sec) sec_rd[p_fn]++; else pri_rd[p_fn]++;
          pend = 0;
        end else wcnt--;
      end
    end
  end

  function automatic int bits2(input logic [15:0] w);
    return int'(w[15]) + int'(w[14]);
  endfunction

  function automatic int sweep_hits();
    int h = 0;
    for (int i = 0; i < NUM_FN; i++)
      if (!fn_skip[i]) begin
        h += bits2(pri_tab[i]);
        if (fn_is_bridge[i]) h += bits2(sec_tab[i]);
      end
    return h;
  endfunction

  function automatic int total_reads();
    int t = 0;
    for (int i = 0; i < NUM_FN; i++) t += pri_rd[i] + sec_rd[i];
    return t;
  endfunction

  task automatic clear_logs();
    for (int i = 0; i < NUM_FN; i++) begin pri_rd[i] = 0; sec_rd[i] = 0; end
    last_key = -1; order_err = 0; stab_err = 0; starts = 0;
  endtask

  task automatic judge(input int sweeps, input int hits);
    int bad_pri = 0, bad_sec = 0, snap;
    for (int s = 0; s < sweeps; s++) begin
      model_cnt = (model_cnt + hits > CMAX) ? CMAX : model_cnt + hits;
    end
    if (panic_en && hits > 0) model_panic = 1;
    for (int i = 0; i < NUM_FN; i++) begin
      if (pri_rd[i] != (fn_skip[i] ? 0 : sweeps)) bad_pri++;
      if (sec_rd[i] != ((fn_skip[i] || !fn_is_bridge[i]) ? 0 : sweeps)) bad_sec++;
    end
    chk(int'(err_count) == model_cnt, "R6 R1 R2 count", int'(err_count), model_cnt);
    chk(bad_pri == 0, "R1 R3 primary reads", bad_pri, 0);
    chk(bad_sec == 0, "R2 R3 secondary reads", bad_sec, 0);
    chk(order_err == 0, "R10 order", order_err, 0);
    chk(stab_err == 0, "R8 request hold", stab_err, 0);
    chk(panic_req == model_panic, "R7 panic", int'(panic_req), int'(model_panic));
    snap = total_reads();
    repeat (300) @(negedge clk);
    chk(total_reads() == snap, "R4 no sweep when disabled", total_reads(), snap);
  endtask

  task automatic one_sweep(input bit check_lat);
    int t0, hits;
    clear_logs();
    hits = sweep_hits();
    @(negedge clk);
    scan_en = 1;
    t0 = cyc;
    repeat (POLL + 3) @(negedge clk);
    scan_en = 0;
    if (check_lat) chk(start_cyc[0] - t0 == POLL, "R4 first sweep latency", start_cyc[0] - t0, POLL);
    repeat (300) @(negedge clk);
    judge(1, hits);
  endtask

  task automatic randomize_tables(input bit allow_skip);
    for (int i = 0; i < NUM_FN; i++) begin
      pri_tab[i] = 16'($urandom());
      sec_tab[i] = 16'($urandom());
      fn_is_bridge[i] = $urandom_range(0, 1);
      fn_skip[i] = allow_skip ? ($urandom_range(0, 3) == 0) : 1'b0;
    end
  endtask

  initial begin : main
    void'($urandom(32'd1357));
    clear_logs();
    repeat (4) @(negedge clk);
    chk(err_count == 0, "R9 reset count", int'(err_count), 0);
    chk(panic_req == 0, "R9 reset panic", int'(panic_req), 0);
    chk(cfg_req == 0, "R9 reset request", int'(cfg_req), 0);
    rst_n = 1;
    repeat (POLL + 20) @(negedge clk);
    chk(total_reads() == 0, "R4 idle while disabled", total_reads(), 0);

    // R1: only bits 15 and 14 count, other bits ignored
    for (int i = 0; i < NUM_FN; i++) begin
      pri_tab[i] = 16'h3FFF; sec_tab[i] = 16'h3FFF;
    end
    fn_is_bridge = 8'hA5; fn_skip = '0; panic_en = 1;
    one_sweep(1);

    // R7: errors with panic disabled
    panic_en = 0;
    randomize_tables(0);
    pri_tab[0] = 16'hC000;
    one_sweep(1);

    // R3: every function skipped
    randomize_tables(0);
    fn_skip = '1;
    one_sweep(0);

    // R5: two back-to-back sweeps
    begin
      int hits;
      randomize_tables(0);
      clear_logs();
      hits = sweep_hits();
      @(negedge clk);
      scan_en = 1;
      while (starts < 2) @(negedge clk);
      scan_en = 0;
      chk(start_cyc[1] - start_cyc[0] == POLL, "R5 sweep period", start_cyc[1] - start_cyc[0], POLL);
      repeat (300) @(negedge clk);
      judge(2, hits);
    end

    // random sweeps
    for (int n = 0; n < 8; n++) begin
      randomize_tables(1);
      panic_en = $urandom_range(0, 1);
      one_sweep(!fn_skip[0]);
    end

    // R6 saturation and R7 panic in the same update
    panic_en = 1;
    for (int i = 0; i < NUM_FN; i++) begin
      pri_tab[i] = 16'hC000; sec_tab[i] = 16'hC000;
    end
    fn_is_bridge = '1; fn_skip = '0;
    one_sweep(1);
    one_sweep(1);
    chk(int'(err_count) == CMAX, "R6 saturation", int'(err_count), CMAX);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule